// File: doc/BRIEF.md
# Masked Event Trigger Combiner

This block watches a wide monitor bus and raises two trigger outputs when a programmed combination of conditions holds. Six event units each pick one 32-bit slice of the bus and test it against their own mask and compare value. The first four units can also be set to report only the cycle in which their match begins.

Four sub-triggers each take the AND of a chosen set of events. Any chosen event can be inverted before the AND. Each of the two final triggers combines the sub-triggers in the same way. A software request forces both triggers. All configuration arrives as plain register inputs. The block registers a level output and a first-cycle pulse output for each trigger. A capture or debug controller uses these outputs to stop or mark its recording.

Top module: `evt_trig_combiner`

## Requirements
- R1: Event k compares bus bits [32*s+31 : 32*s], where s is the 3-bit source field evt_src_i[3k+2:3k]. Event A is k=0 and event F is k=5.
- R2: An event's raw match is true when ((slice XOR compare) AND mask) is zero. A mask bit of 0 removes that bit from the test, so an all-zero mask always matches.
- R3: Events A to D have a mode bit, evt_edge_i[k]. With the bit at 0 the event follows its raw match. With the bit at 1 the event is true only in a cycle where the raw match is true and the raw match of the previous cycle was false. Events E and F always follow their raw match.
- R4: Sub-trigger j is true when its 6-bit AND field sub_and_i[6j+5:6j] is non-zero and, for every set bit i of that field, event i XOR bit i of sub_not_i[6j+5:6j] is 1. An all-zero AND field keeps the sub-trigger false.
- R5: Trigger 1 is true when trg1_and_i is non-zero and, for every set bit j, sub-trigger j XOR trg1_inv_i[j] is 1. An all-zero trg1_and_i keeps trigger 1 false.
- R6: Trigger 2 follows the rule of R5, using trg2_and_i and trg2_inv_i.
- R7: When sw_trig_i is high, both triggers are true, whatever the event logic gives.
- R8: trg1_o and trg2_o show the trigger value computed from the inputs of the cycle before. They change only after a rising clock edge.
- R9: trgN_pulse_o is high for exactly the cycle in which trgN_o goes from 0 to 1.
- R10: While rst_ni is low, all four outputs are 0, even when sw_trig_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mon_bus_i | input | 256 | Monitor bus, eight 32-bit slices |
| evt_src_i | input | 18 | Slice select, 3 bits per event |
| evt_mask_i | input | 192 | Compare mask, 32 bits per event |
| evt_cmp_i | input | 192 | Compare value, 32 bits per event |
| evt_edge_i | input | 4 | Rising-edge mode for events A to D |
| sub_and_i | input | 24 | Event selection, 6 bits per sub-trigger |
| sub_not_i | input | 24 | Event inversion, 6 bits per sub-trigger |
| trg1_and_i | input | 4 | Sub-trigger selection for trigger 1 |
| trg1_inv_i | input | 4 | Sub-trigger inversion for trigger 1 |
| trg2_and_i | input | 4 | Sub-trigger selection for trigger 2 |
| trg2_inv_i | input | 4 | Sub-trigger inversion for trigger 2 |
| sw_trig_i | input | 1 | Software trigger request |
| trg1_o | output | 1 | Trigger 1 level, registered |
| trg2_o | output | 1 | Trigger 2 level, registered |
| trg1_pulse_o | output | 1 | First cycle of trigger 1 |
| trg2_pulse_o | output | 1 | First cycle of trigger 2 |

## Verification
The assertions assume that every configuration input is stable from one rising edge to the next. They also assume a single edge-mode event stays in edge mode for two consecutive cycles when its single-cycle property is checked. The bench therefore changes all inputs only on the falling edge, once per step. It holds each edge-mode setting across the whole run of cycles that tests it. It models the previous-cycle match of every event from the same stepped inputs, which starts at 0 after reset.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
  localparam int unsigned SLICE_W  = 32;
  localparam int unsigned SRC_W    = 3;
  localparam int unsigned NUM_EVT  = 6;
  localparam int unsigned NUM_EDGE = 4;
  localparam int unsigned NUM_SUB  = 4;
  localparam int unsigned NUM_TRG  = 2;
endpackage

// File: rtl/evt_match_unit.sv
module evt_match_unit #(
  parameter int unsigned SLICE_W = 32,
  parameter int unsigned SRC_W   = 3,
  localparam int unsigned NSLICE = 1 << SRC_W,
  localparam int unsigned BUS_W  = SLICE_W * NSLICE
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [BUS_W-1:0]   bus_i,
  input  logic [SRC_W-1:0]   src_i,
  input  logic [SLICE_W-1:0] mask_i,
  input  logic [SLICE_W-1:0] cmp_i,
  input  logic               edge_i,
  output logic               hit_o
);
  logic [SLICE_W-1:0] slices [NSLICE];
  logic [SLICE_W-1:0] slice;
  logic               raw;
  logic               prev_q;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    assign slices[s] = bus_i[s*SLICE_W +: SLICE_W];
  end

  assign slice = slices[src_i];
  assign raw   = ~|((slice ^ cmp_i) & mask_i);

  // previous raw match, kept in both modes so switching mode is glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= raw;
  end

  assign hit_o = edge_i ? (raw & ~prev_q) : raw;

  // R3: an edge-mode hit never lasts two cycles
  assert_edge_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && hit_o) |=> (!edge_i || !hit_o))
    else $error("edge-mode hit held for two cycles");
endmodule

// File: rtl/and_not_reduce.sv
module and_not_reduce #(
  parameter int unsigned W = 6
) (
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] inv_i,
  output logic         out_o
);
  logic [W-1:0] term;

  // unselected inputs read as 1; selected ones pass through their inversion
  assign term  = ~sel_i | (in_i ^ inv_i);
  assign out_o = (|sel_i) & (&term);
endmodule

// File: rtl/evt_trig_combiner.sv
module evt_trig_combiner
  import evt_trig_pkg::*;
#(
  parameter int unsigned SLICE_W_P  = SLICE_W,
  parameter int unsigned SRC_W_P    = SRC_W,
  parameter int unsigned NUM_EVT_P  = NUM_EVT,
  parameter int unsigned NUM_EDGE_P = NUM_EDGE,
  parameter int unsigned NUM_SUB_P  = NUM_SUB,
  localparam int unsigned BUS_W     = SLICE_W_P * (1 << SRC_W_P)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [BUS_W-1:0]                mon_bus_i,
  input  logic [NUM_EVT_P*SRC_W_P-1:0]    evt_src_i,
  input  logic [NUM_EVT_P*SLICE_W_P-1:0]  evt_mask_i,
  input  logic [NUM_EVT_P*SLICE_W_P-1:0]  evt_cmp_i,
  input  logic [NUM_EDGE_P-1:0]           evt_edge_i,
  input  logic [NUM_SUB_P*NUM_EVT_P-1:0]  sub_and_i,
  input  logic [NUM_SUB_P*NUM_EVT_P-1:0]  sub_not_i,
  input  logic [NUM_SUB_P-1:0]            trg1_and_i,
  input  logic [NUM_SUB_P-1:0]            trg1_inv_i,
  input  logic [NUM_SUB_P-1:0]            trg2_and_i,
  input  logic [NUM_SUB_P-1:0]            trg2_inv_i,
  input  logic                            sw_trig_i,
  output logic                            trg1_o,
  output logic                            trg2_o,
  output logic                            trg1_pulse_o,
  output logic                            trg2_pulse_o
);
  logic [NUM_EVT_P-1:0] evt_hit;
  logic [NUM_SUB_P-1:0] sub_hit;
  logic [1:0]           trg_sel_and [2];
  logic [NUM_SUB_P-1:0] trg_and [2];
  logic [NUM_SUB_P-1:0] trg_inv [2];
  logic [1:0]           trg_comb;
  logic [1:0]           trg_d, trg_q, pls_q;

  for (genvar k = 0; k < NUM_EVT_P; k++) begin : g_evt
    logic edge_mode;
    if (k < NUM_EDGE_P) begin : g_edge
      assign edge_mode = evt_edge_i[k];
    end else begin : g_level
      assign edge_mode = 1'b0;
    end
    evt_match_unit #(
      .SLICE_W (SLICE_W_P),
      .SRC_W   (SRC_W_P)
    ) u_evt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bus_i  (mon_bus_i),
      .src_i  (evt_src_i[k*SRC_W_P +: SRC_W_P]),
      .mask_i (evt_mask_i[k*SLICE_W_P +: SLICE_W_P]),
      .cmp_i  (evt_cmp_i[k*SLICE_W_P +: SLICE_W_P]),
      .edge_i (edge_mode),
      .hit_o  (evt_hit[k])
    );
  end

  for (genvar j = 0; j < NUM_SUB_P; j++) begin : g_sub
    and_not_reduce #(.W(NUM_EVT_P)) u_sub (
      .in_i  (evt_hit),
      .sel_i (sub_and_i[j*NUM_EVT_P +: NUM_EVT_P]),
      .inv_i (sub_not_i[j*NUM_EVT_P +: NUM_EVT_P]),
      .out_o (sub_hit[j])
    );
  end

  assign trg_and[0] = trg1_and_i;
  assign trg_inv[0] = trg1_inv_i;
  assign trg_and[1] = trg2_and_i;
  assign trg_inv[1] = trg2_inv_i;

  for (genvar t = 0; t < 2; t++) begin : g_trg
    and_not_reduce #(.W(NUM_SUB_P)) u_trg (
      .in_i  (sub_hit),
      .sel_i (trg_and[t]),
      .inv_i (trg_inv[t]),
      .out_o (trg_comb[t])
    );
    assign trg_d[t] = trg_comb[t] | sw_trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trg_q <= '0;
      pls_q <= '0;
    end else begin
      trg_q <= trg_d;
      pls_q <= trg_d & ~trg_q;
    end
  end

  assign trg1_o       = trg_q[0];
  assign trg2_o       = trg_q[1];
  assign trg1_pulse_o = pls_q[0];
  assign trg2_pulse_o = pls_q[1];

  assert_sw_force_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_trig_i |=> (trg1_o && trg2_o))
    else $error("software request did not force both triggers");

  assert_empty_trg1_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg1_and_i == '0 && !sw_trig_i) |=> !trg1_o)
    else $error("trigger 1 fired with empty selection");

  assert_empty_trg2_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg2_and_i == '0 && !sw_trig_i) |=> !trg2_o)
    else $error("trigger 2 fired with empty selection");

  assert_pulse1_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg1_pulse_o |-> (trg1_o && !$past(trg1_o)))
    else $error("trigger 1 pulse not on first level cycle");

  assert_pulse2_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trg2_pulse_o |-> (trg2_o && !$past(trg2_o)))
    else $error("trigger 2 pulse not on first level cycle");

  assert_pulse_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trg1_o) |-> trg1_pulse_o)
    else $error("trigger 1 rose without pulse");
endmodule

// File: tb/evt_trig_combiner_tb.sv
`timescale 1ns/1ps
module evt_trig_combiner_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] bus = '0;
  logic [17:0]  src = '0;
  logic [191:0] mask = '0;
  logic [191:0] cmp = '0;
  logic [3:0]   edg = '0;
  logic [23:0]  sand = '0;
  logic [23:0]  snot = '0;
  logic [3:0]   t1a = '0, t1i = '0, t2a = '0, t2i = '0;
  logic         sw = 1'b0;
  logic         trg1, trg2, pls1, pls2;

  int checks = 0;
  int errors = 0;
  logic [5:0] mprev = '0;
  logic [1:0] lprev = '0;

  always #4 clk = ~clk;

  evt_trig_combiner u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mon_bus_i(bus), .evt_src_i(src),
    .evt_mask_i(mask), .evt_cmp_i(cmp), .evt_edge_i(edg),
    .sub_and_i(sand), .sub_not_i(snot),
    .trg1_and_i(t1a), .trg1_inv_i(t1i), .trg2_and_i(t2a), .trg2_inv_i(t2i),
    .sw_trig_i(sw), .trg1_o(trg1), .trg2_o(trg2),
    .trg1_pulse_o(pls1), .trg2_pulse_o(pls2)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic comb4(input logic [3:0] v, input logic [3:0] a, input logic [3:0] n);
    logic ok = (a != 0);
    for (int i = 0; i < 4; i++) if (a[i] && !(v[i] ^ n[i])) ok = 1'b0;
    return ok;
  endfunction

  task automatic model(output logic [5:0] raw, output logic e1, output logic e2);
    logic [5:0] ev;
    logic [3:0] sub;
    logic [31:0] sl;
    for (int k = 0; k < 6; k++) begin
      sl = bus[int'(src[k*3 +: 3])*32 +: 32];
      raw[k] = (((sl ^ cmp[k*32 +: 32]) & mask[k*32 +: 32]) == 32'd0);
      ev[k] = raw[k];
      if (k < 4) if (edg[k]) ev[k] = raw[k] & ~mprev[k];
    end
    for (int j = 0; j < 4; j++) begin
      logic ok = (sand[j*6 +: 6] != 0);
      for (int i = 0; i < 6; i++)
        if (sand[j*6+i] && !(ev[i] ^ snot[j*6+i])) ok = 1'b0;
      sub[j] = ok;
    end
    e1 = comb4(sub, t1a, t1i) | sw;
    e2 = comb4(sub, t2a, t2i) | sw;
  endtask

  // one cycle: inputs already set after a falling edge; check at next falling edge
  task automatic step(input string tag);
    logic [5:0] raw;
    logic e1, e2;
    model(raw, e1, e2);
    @(posedge clk);
    mprev = raw;
    @(negedge clk);
    chk(tag, "trg1_o", trg1, e1);
    chk(tag, "trg2_o", trg2, e2);
    chk("R9", "trg1_pulse_o", pls1, e1 & ~lprev[0]);
    chk("R9", "trg2_pulse_o", pls2, e2 & ~lprev[1]);
    lprev = {e2, e1};
  endtask

  // event k forced to match (mask 0) or miss (full mask on a differing compare)
  task automatic set_events(input logic [5:0] want);
    bus = '0;
    for (int k = 0; k < 6; k++) begin
      src[k*3 +: 3] = 3'(k);
      cmp[k*32 +: 32] = 32'h1;
      mask[k*32 +: 32] = want[k] ? 32'h0 : 32'hFFFF_FFFF;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset holds outputs low even with a software request
    sw = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", "trg1_o", trg1, 1'b0);
    chk("R10", "trg2_o", trg2, 1'b0);
    chk("R10", "trg1_pulse_o", pls1, 1'b0);
    chk("R10", "trg2_pulse_o", pls2, 1'b0);
    sw = 1'b0;
    rst_n = 1'b1;
    step("R10");

    // R1: slice select for event A through sub 0 and trigger 1
    sand[5:0] = 6'b000001; t1a = 4'b0001;
    for (int s = 0; s < 8; s++) bus[s*32 +: 32] = 32'h1357_0000 + 32'(s * 32'h0101);
    mask[31:0] = 32'hFFFF_FFFF;
    for (int s = 0; s < 8; s++) begin
      src[2:0] = 3'(s);
      cmp[31:0] = bus[s*32 +: 32];
      step("R1");
      cmp[31:0] = bus[((s + 1) % 8)*32 +: 32];
      step("R1");
    end

    // R2: masked-out difference is ignored, a masked-in one is not
    src[2:0] = 3'd2;
    for (int b = 0; b < 32; b++) begin
      cmp[31:0] = bus[64 +: 32] ^ (32'h1 << b);
      mask[31:0] = ~(32'h1 << b);
      step("R2");
      mask[31:0] = 32'h1 << b;
      step("R2");
    end
    mask[31:0] = 32'h0; cmp[31:0] = 32'hDEAD_BEEF;
    step("R2");

    // R8: output holds until the clock edge
    mask[31:0] = 32'hFFFF_FFFF;
    step("R8");
    cmp[31:0] = bus[64 +: 32];
    #1;
    chk("R8", "trg1_o before edge", trg1, 1'b0);
    step("R8");

    // R3: edge mode on event A
    cmp[31:0] = 32'h0;
    step("R3");
    edg[0] = 1'b1;
    cmp[31:0] = bus[64 +: 32];
    repeat (3) step("R3");
    cmp[31:0] = 32'h0;
    step("R3");
    cmp[31:0] = bus[64 +: 32];
    step("R3");
    edg[0] = 1'b0;
    repeat (2) step("R3");
    // events E and F have no edge mode: level only
    sand[5:0] = 6'b110000;
    set_events(6'b110000);
    edg = 4'hF;
    repeat (3) step("R3");
    edg = '0;

    // R4: every AND selection against every event vector on sub 0
    t1a = 4'b0001; t1i = '0; t2a = '0; t2i = '0;
    for (int v = 0; v < 64; v++) begin
      set_events(6'(v));
      for (int a = 0; a < 64; a++) begin
        sand[5:0] = 6'(a);
        snot[5:0] = 6'((a * 7 + v * 3) & 63);
        step("R4");
      end
    end
    // R4: sub-triggers 1..3 through trigger 1 inversion
    for (int j = 1; j < 4; j++) begin
      sand = '0; snot = '0;
      sand[j*6 +: 6] = 6'b000101; snot[j*6 +: 6] = 6'b000100;
      t1a = 4'(1 << j);
      set_events(6'b000001); step("R4");
      set_events(6'b000101); step("R4");
      t1i = 4'(1 << j); step("R4");
      t1i = '0;
    end

    // R5, R6: every trigger selection against every sub-trigger vector
    sand = '0; snot = '0;
    for (int j = 0; j < 4; j++) sand[j*6 +: 6] = 6'(1 << j);
    for (int v = 0; v < 16; v++) begin
      set_events(6'(v));
      for (int a = 0; a < 16; a++)
        for (int n = 0; n < 16; n++) begin
          t1a = 4'(a); t1i = 4'(n);
          t2a = 4'(a ^ 5); t2i = 4'(n ^ 9);
          step("R5");
        end
    end
    t1a = '0; t2a = '0;
    step("R6");

    // R7: software request with an empty configuration
    sw = 1'b1; step("R7"); step("R7");
    sw = 1'b0; step("R7");

    // mixed sweep with biased stimulus
    for (int c = 0; c < 2000; c++) begin
      if (c % 16 == 0) begin
        src = 18'($urandom); edg = 4'($urandom);
        for (int k = 0; k < 6; k++) begin
          mask[k*32 +: 32] = $urandom;
          cmp[k*32 +: 32] = $urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0;
        end
        for (int j = 0; j < 4; j++) begin
          sand[j*6 +: 6] = 6'($urandom & $urandom);
          snot[j*6 +: 6] = 6'($urandom);
        end
        t1a = 4'($urandom); t1i = 4'($urandom);
        t2a = 4'($urandom); t2i = 4'($urandom);
      end
      for (int s = 0; s < 8; s++) bus[s*32 +: 32] = $urandom_range(0, 1) ? 32'hFFFF_FFFF : 32'h0;
      sw = ($urandom_range(0, 31) == 0);
      step("R6");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule